// File: doc/BRIEF.md
# Busy-Release Completion Monitor

Some SD host cores report a command as finished while the card is still holding the data line low to signal that it is busy. This happens for a short-response-with-busy command that carries no data. It also happens for the busy phase that follows an automatic stop command at the end of a multi-block transfer. This block sits between such a core and the interrupt status that software reads. It watches command writes and arms itself for either case. It captures the core's early completion bit, hides that bit from software while the card stays busy, and polls the data-line status on a slow tick. When the card lets go, the block injects completion bits of its own. If a deadline passes first, it injects a timeout bit instead.

Software reads a merged view of the status, which is the raw status ORed with the synthetic bits. A write-one-to-clear of that view clears the synthetic bits it selects. The hardware clear strobe goes back to the core so that the core drops its premature bit. The tick period and the deadline are parameters: `TICK_CYC` is the number of clock cycles per poll, and `DEADLINE_MS` is the number of polls before the timeout.

Top module: `busy_release_monitor`

## Requirements
- R1: After synchronous reset, `merged_stat`, `hw_clr_stb`, `hw_clr_mask`, `rsp_irq_force` and `syn_irq` are all zero.
- R2: A `cmd_wr` pulse with `cmd_has_data`=0 and `cmd_rsp_type`=2'b11 (short with busy) arms no-data mode, and `rsp_irq_force` is 1 from the next cycle until completion. Response types 2'b00, 2'b01 and 2'b10 do not arm the block.
- R3: A `cmd_wr` pulse with `cmd_has_data`=1 arms auto-stop mode only when `xfer_auto_stop` and `xfer_multi_blk` are both 1. If either is 0, a later raw status produces no clear strobe and no synthetic bits.
- R4: In no-data mode the block captures raw bit 0 (RESPONSE). In auto-stop mode it captures raw bit 1 (DATA_END). Other raw bits do not trigger a capture.
- R5: The card counts as busy while `dat_line_active` or `dat_inhibit` is 1. A capture made while busy gives a one-cycle `hw_clr_stb`, with `hw_clr_mask` holding only the captured bit.
- R6: A capture made while not busy latches the synthetic bits at once: bit 1 (DATA_END), plus bit 0 (RESPONSE) in no-data mode. `syn_irq` is high in the cycle after the capture edge.
- R7: While waiting, busy is sampled only on a poll tick, every `TICK_CYC` cycles after capture. Release seen at poll k latches the bits of R6, with `syn_irq` high k*`TICK_CYC`+1 cycles after the arming edge.
- R8: If the card is still busy at poll `DEADLINE_MS`, only bit 20 (DATA_TIMEOUT) is latched. A release seen at that same poll yields the R6 bits instead.
- R9: `merged_stat` is a register that holds the raw status of the previous cycle ORed with the synthetic bits as updated at that edge.
- R10: A `stat_w1c_wr` clears each synthetic bit whose `stat_w1c_data` bit is 1 and leaves the other synthetic bits unchanged.
- R11: When a synthetic bit is latched in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R12: `syn_irq` is a one-cycle pulse for each completion or timeout, and the mode returns to idle at that edge (`rsp_irq_force` falls with it).
- R13: While the block is armed or waiting, further arming commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Pulse: command register written |
| cmd_has_data | input | 1 | Written command carries data |
| cmd_rsp_type | input | 2 | Response type of written command (2'b11 = short with busy) |
| xfer_auto_stop | input | 1 | Transfer mode: automatic stop command enabled |
| xfer_multi_blk | input | 1 | Transfer mode: multi-block transfer |
| raw_stat | input | STAT_W | Raw interrupt status from the core |
| dat_line_active | input | 1 | Present state: data line active |
| dat_inhibit | input | 1 | Present state: data inhibit |
| stat_w1c_wr | input | 1 | Software write-one-to-clear strobe |
| stat_w1c_data | input | STAT_W | Bits to clear |
| merged_stat | output | STAT_W | Raw status ORed with synthetic bits |
| hw_clr_stb | output | 1 | Strobe: clear bits in the core's status |
| hw_clr_mask | output | STAT_W | Bits to clear in the core |
| rsp_irq_force | output | 1 | Force the response interrupt on in the enable and signal masks |
| syn_irq | output | 1 | One-cycle request after synthetic bits are latched |

## Verification
Latching a synthetic bit and a software write-one-to-clear can land on the same clock edge. The bench provokes this by leaving RESPONSE and DATA_END set from a no-data completion. It then completes an auto-stop command with the card not busy, and on the capture edge it writes ones to both bits. The merged view is judged on the following two cycles. DATA_END must survive because it was set again on that edge, and RESPONSE must be gone. A second overlap is a release that arrives on the very poll that reaches the deadline. The bench drops busy just before that poll and expects DATA_END rather than DATA_TIMEOUT.

// File: rtl/bsy_pkg.sv
package bsy_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_NODATA   = 2'd1,
    MODE_AUTOSTOP = 2'd2
  } mode_e;

  localparam int BIT_RESP = 0;
  localparam int BIT_DEND = 1;
  localparam int BIT_DTO  = 20;
  localparam logic [1:0] RSP_SHORT_BUSY = 2'b11;
endpackage

// File: rtl/bsy_tick_timer.sv
module bsy_tick_timer #(
  parameter int TICK_CYC    = 100000,
  parameter int DEADLINE_MS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic tick,
  output logic last_tick
);
  localparam int TW = $clog2(TICK_CYC + 1);
  localparam int MW = $clog2(DEADLINE_MS + 1);

  logic [TW-1:0] tcnt;
  logic [MW-1:0] mcnt;

  assign tick      = run && (tcnt == TW'(TICK_CYC - 1));
  assign last_tick = tick && (mcnt >= MW'(DEADLINE_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      tcnt <= '0;
      mcnt <= '0;
    end else if (run) begin
      if (tick) begin
        tcnt <= '0;
        if (mcnt != MW'(DEADLINE_MS)) mcnt <= mcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R7
endmodule

// File: rtl/bsy_ctrl.sv
module bsy_ctrl
  import bsy_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_has_data,
  input  logic [1:0]        cmd_rsp_type,
  input  logic              xfer_auto_stop,
  input  logic              xfer_multi_blk,
  input  logic [STAT_W-1:0] raw_stat,
  input  logic              busy,
  input  logic              tick,
  input  logic              last_tick,
  output logic              timer_start,
  output logic              timer_run,
  output logic [STAT_W-1:0] syn_set,
  output logic              hw_clr_stb,
  output logic [STAT_W-1:0] hw_clr_mask,
  output logic              rsp_force
);
  localparam logic [STAT_W-1:0] M_RESP = STAT_W'(1) << BIT_RESP;
  localparam logic [STAT_W-1:0] M_DEND = STAT_W'(1) << BIT_DEND;
  localparam logic [STAT_W-1:0] M_DTO  = STAT_W'(1) << BIT_DTO;

  mode_e mode_q;
  logic  wait_q;
  logic  arm_nd, arm_ac, capture, finish;
  logic [STAT_W-1:0] cap_mask, done_mask;

  assign arm_nd = cmd_wr && !cmd_has_data && (cmd_rsp_type == RSP_SHORT_BUSY);
  assign arm_ac = cmd_wr && cmd_has_data && xfer_auto_stop && xfer_multi_blk;

  always_comb begin
    unique case (mode_q)
      MODE_NODATA:   cap_mask = M_RESP;
      MODE_AUTOSTOP: cap_mask = M_DEND;
      default:       cap_mask = '0;
    endcase
  end

  assign done_mask = M_DEND | ((mode_q == MODE_NODATA) ? M_RESP : '0);
  assign capture   = (mode_q != MODE_IDLE) && !wait_q && (|(raw_stat & cap_mask));

  always_comb begin
    syn_set = '0;
    if (capture && !busy)
      syn_set = done_mask;
    else if (wait_q && tick) begin
      if (!busy)          syn_set = done_mask;
      else if (last_tick) syn_set = M_DTO;
    end
  end

  assign finish      = |syn_set;
  assign timer_start = capture && busy;
  assign timer_run   = wait_q;
  assign rsp_force   = (mode_q == MODE_NODATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_IDLE;
      wait_q      <= 1'b0;
      hw_clr_stb  <= 1'b0;
      hw_clr_mask <= '0;
    end else begin
      hw_clr_stb  <= capture && busy;
      hw_clr_mask <= (capture && busy) ? cap_mask : '0;
      if (finish) begin
        mode_q <= MODE_IDLE;
        wait_q <= 1'b0;
      end else if (capture) begin
        wait_q <= 1'b1;
      end else if (mode_q == MODE_IDLE) begin
        if (arm_nd)      mode_q <= MODE_NODATA;
        else if (arm_ac) mode_q <= MODE_AUTOSTOP;
      end
    end
  end

  AST_CLR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    hw_clr_stb |-> $past(busy)); // R5
  AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_IDLE) |=> (mode_q == $past(mode_q) || mode_q == MODE_IDLE)); // R13
  AST_TIMEOUT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(syn_set[BIT_DTO] && syn_set[BIT_DEND])); // R8
  AST_IDLE_AFTER_SET: assert property (@(posedge clk) disable iff (rst)
    (|syn_set) |=> (mode_q == MODE_IDLE) && !wait_q); // R12
endmodule

// File: rtl/bsy_syn_reg.sv
module bsy_syn_reg #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  output logic [STAT_W-1:0] q,
  output logic [STAT_W-1:0] nxt
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    assign nxt[i] = set[i] | (q[i] & ~(clr_wr & clr_data[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((q & $past(set)) == $past(set))); // R11
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((q & $past(clr_data & ~set)) == '0)); // R10
endmodule

// File: rtl/busy_release_monitor.sv
module busy_release_monitor #(
  parameter int STAT_W      = 32,
  parameter int TICK_CYC    = 100000,
  parameter int DEADLINE_MS = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_has_data,
  input  logic [1:0]        cmd_rsp_type,
  input  logic              xfer_auto_stop,
  input  logic              xfer_multi_blk,
  input  logic [STAT_W-1:0] raw_stat,
  input  logic              dat_line_active,
  input  logic              dat_inhibit,
  input  logic              stat_w1c_wr,
  input  logic [STAT_W-1:0] stat_w1c_data,
  output logic [STAT_W-1:0] merged_stat,
  output logic              hw_clr_stb,
  output logic [STAT_W-1:0] hw_clr_mask,
  output logic              rsp_irq_force,
  output logic              syn_irq
);
  logic              busy, tick, last_tick, t_start, t_run;
  logic [STAT_W-1:0] syn_set, syn_q, syn_nxt;

  assign busy = dat_line_active | dat_inhibit;

  bsy_tick_timer #(.TICK_CYC(TICK_CYC), .DEADLINE_MS(DEADLINE_MS)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .run(t_run),
    .tick(tick), .last_tick(last_tick));

  bsy_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_has_data(cmd_has_data),
    .cmd_rsp_type(cmd_rsp_type), .xfer_auto_stop(xfer_auto_stop),
    .xfer_multi_blk(xfer_multi_blk), .raw_stat(raw_stat), .busy(busy),
    .tick(tick), .last_tick(last_tick), .timer_start(t_start),
    .timer_run(t_run), .syn_set(syn_set), .hw_clr_stb(hw_clr_stb),
    .hw_clr_mask(hw_clr_mask), .rsp_force(rsp_irq_force));

  bsy_syn_reg #(.STAT_W(STAT_W)) u_syn (
    .clk(clk), .rst(rst), .set(syn_set), .clr_wr(stat_w1c_wr),
    .clr_data(stat_w1c_data), .q(syn_q), .nxt(syn_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      merged_stat <= '0;
      syn_irq     <= 1'b0;
    end else begin
      merged_stat <= raw_stat | syn_nxt;
      syn_irq     <= |syn_set;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    syn_irq |=> !syn_irq); // R12
  AST_MERGE_HAS_SYN: assert property (@(posedge clk) disable iff (rst)
    ((merged_stat & syn_q) == syn_q)); // R9
endmodule

// File: tb/busy_release_monitor_tb.sv
module busy_release_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;
  localparam int DL   = 3;
  localparam int SW   = 32;
  localparam logic [SW-1:0] RESP = 32'h1;
  localparam logic [SW-1:0] DEND = 32'h2;
  localparam logic [SW-1:0] DTO  = 32'h0010_0000;

  // row: {nd, busy source (0 active, 1 inhibit, 2 both), polls busy k}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd0}, {1'b0, 2'd1, 5'd0}, {1'b1, 2'd0, 5'd1}, {1'b0, 2'd1, 5'd2},
    {1'b1, 2'd2, 5'd3}, {1'b0, 2'd0, 5'd4}, {1'b1, 2'd1, 5'd5}, {1'b0, 2'd2, 5'd1}};

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_wr = 0, cmd_has_data = 0, xfer_auto_stop = 0, xfer_multi_blk = 0;
  logic [1:0] cmd_rsp_type = 2'b00;
  logic [SW-1:0] raw_stat = '0, stat_w1c_data = '0;
  logic dat_line_active = 0, dat_inhibit = 0, stat_w1c_wr = 0;
  logic [SW-1:0] merged_stat, hw_clr_mask;
  logic hw_clr_stb, rsp_irq_force, syn_irq;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busy_release_monitor #(.STAT_W(SW), .TICK_CYC(TICK), .DEADLINE_MS(DL)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_has_data(cmd_has_data),
    .cmd_rsp_type(cmd_rsp_type), .xfer_auto_stop(xfer_auto_stop),
    .xfer_multi_blk(xfer_multi_blk), .raw_stat(raw_stat),
    .dat_line_active(dat_line_active), .dat_inhibit(dat_inhibit),
    .stat_w1c_wr(stat_w1c_wr), .stat_w1c_data(stat_w1c_data),
    .merged_stat(merged_stat), .hw_clr_stb(hw_clr_stb), .hw_clr_mask(hw_clr_mask),
    .rsp_irq_force(rsp_irq_force), .syn_irq(syn_irq));

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic nd);
    @(negedge clk);
    cmd_wr = 1;
    if (nd) begin cmd_has_data = 0; cmd_rsp_type = 2'b11; xfer_auto_stop = 0; xfer_multi_blk = 0; end
    else    begin cmd_has_data = 1; cmd_rsp_type = 2'b10; xfer_auto_stop = 1; xfer_multi_blk = 1; end
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic clear_all();
    stat_w1c_wr = 1; stat_w1c_data = '1;
    @(negedge clk);
    stat_w1c_wr = 0; stat_w1c_data = '0;
  endtask

  task automatic do_case(input logic nd, input logic [1:0] src, input int k, input bit clr);
    logic [SW-1:0] cap, exp_syn;
    int lat, exp_lat;
    lat = -1;
    cap = nd ? RESP : DEND;
    issue(nd);
    chk("R2 force after arm", {31'd0, rsp_irq_force}, {31'd0, nd});
    raw_stat = cap;
    dat_line_active = (k > 0) && (src != 2'd1);
    dat_inhibit     = (k > 0) && (src != 2'd0);
    for (int cyc = 1; cyc <= DL*TICK + 8; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        raw_stat = '0;
        chk("R5 clear strobe", {31'd0, hw_clr_stb}, {31'd0, k > 0});
        chk("R5 clear mask", hw_clr_mask, (k > 0) ? cap : '0);
      end
      if (k > 0 && k <= DL && cyc == (k-1)*TICK + 1) begin
        dat_line_active = 0; dat_inhibit = 0;
      end
      if (syn_irq) begin lat = cyc; break; end
    end
    dat_line_active = 0; dat_inhibit = 0;
    exp_lat = (k == 0) ? 1 : ((k <= DL) ? k*TICK + 1 : DL*TICK + 1);
    exp_syn = (k <= DL) ? (DEND | (nd ? RESP : '0)) : DTO;
    chk((k == 0) ? "R6 latency" : ((k <= DL) ? "R7 latency" : "R8 latency"), SW'(lat), SW'(exp_lat));
    chk((k <= DL) ? "R6 done bits" : "R8 timeout bits", merged_stat, exp_syn | ((k == 0) ? cap : '0));
    chk("R12 mode idle", {31'd0, rsp_irq_force}, 32'd0);
    @(negedge clk);
    chk("R12 one pulse", {31'd0, syn_irq}, 32'd0);
    chk("R9 merged hold", merged_stat, exp_syn);
    if (clr) begin
      clear_all();
      chk("R10 clear all", merged_stat, '0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 merged", merged_stat, '0);
    chk("R1 outs", {28'd0, hw_clr_stb, rsp_irq_force, syn_irq, |hw_clr_mask}, '0);

    for (int i = 0; i < NV; i++)
      do_case(VEC[i][7], VEC[i][6:5], int'(VEC[i][4:0]), 1'b1);

    // R2 non-arming response types
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      cmd_wr = 1; cmd_has_data = 0; cmd_rsp_type = 2'(t); xfer_auto_stop = 0; xfer_multi_blk = 0;
      @(negedge clk);
      cmd_wr = 0;
      chk("R2 no arm type", {31'd0, rsp_irq_force}, 32'd0);
    end
    raw_stat = RESP; dat_line_active = 1;
    repeat (2) begin
      @(negedge clk);
      chk("R2 no capture", {30'd0, hw_clr_stb, syn_irq}, 32'd0);
    end
    raw_stat = '0; dat_line_active = 0;

    // R3 partial transfer mode does not arm
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      cmd_wr = 1; cmd_has_data = 1; cmd_rsp_type = 2'b10;
      xfer_auto_stop = (v == 0); xfer_multi_blk = (v == 1);
      @(negedge clk);
      cmd_wr = 0; raw_stat = DEND; dat_inhibit = 1;
      @(negedge clk);
      chk("R3 no arm", {30'd0, hw_clr_stb, syn_irq}, 32'd0);
      raw_stat = '0; dat_inhibit = 0;
      @(negedge clk);
      chk("R3 no syn", merged_stat, '0);
    end

    // R4 auto-stop ignores RESPONSE
    issue(1'b0);
    raw_stat = RESP; dat_line_active = 1;
    repeat (2) begin
      @(negedge clk);
      chk("R4 wrong bit ignored", {30'd0, hw_clr_stb, syn_irq}, 32'd0);
    end
    raw_stat = DEND; dat_line_active = 0;
    @(negedge clk);
    raw_stat = '0;
    chk("R4 capture DATA_END", {31'd0, syn_irq}, 32'd1);
    clear_all();

    // R13 rearm while waiting is ignored
    issue(1'b0);
    raw_stat = DEND; dat_line_active = 1;
    @(negedge clk);
    raw_stat = '0;
    issue(1'b1);
    chk("R13 no rearm", {31'd0, rsp_irq_force}, 32'd0);
    dat_line_active = 0;
    for (int c = 0; c < 2*TICK && !syn_irq; c++) @(negedge clk);
    chk("R13 auto-stop bits only", merged_stat, DEND);
    clear_all();

    // R10 partial clear
    do_case(1'b1, 2'd0, 0, 1'b0);
    stat_w1c_wr = 1; stat_w1c_data = RESP;
    @(negedge clk);
    stat_w1c_wr = 0;
    chk("R10 partial clear", merged_stat, DEND);
    stat_w1c_wr = 1; stat_w1c_data = DEND;
    @(negedge clk);
    stat_w1c_wr = 0;
    chk("R10 second clear", merged_stat, '0);

    // R11 set and clear on the same edge
    do_case(1'b1, 2'd0, 0, 1'b0);
    issue(1'b0);
    raw_stat = DEND; stat_w1c_wr = 1; stat_w1c_data = RESP | DEND;
    @(negedge clk);
    raw_stat = '0; stat_w1c_wr = 0; stat_w1c_data = '0;
    chk("R11 irq", {31'd0, syn_irq}, 32'd1);
    chk("R11 merged at edge", merged_stat, DEND);
    @(negedge clk);
    chk("R11 set wins", merged_stat, DEND);
    clear_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule